// File: doc/BRIEF.md
# Waveform Timer Channel

A single up-counting timer channel that produces a pulse waveform and compare events. The counter advances on a one-cycle tick. The tick comes from one of five prescaler taps of the system clock or from one of three external clock lines. An external line can be counted on its falling edge instead of its rising edge, and the tick can be gated by the level of a second external line. Every tick is qualified in the system clock domain, so the block has a single clock.

Two compare registers shape the output. The duty compare sets the waveform and the period compare clears it. On a period match the counter returns to zero on the next tick. The period match can also stop the channel for a single-shot interval. A software trigger or a qualified external trigger edge restarts the count and clears the waveform. Period-match and overflow events latch into status flags that clear when read, and each flag can drive the interrupt line through a mask.

A host reaches the block through a simple word-addressed register port with a combinational read path. Reads of the status word take effect at the clock edge that ends the read.

Top module: `wtc_channel`

## Requirements
- R1: After reset, the waveform and interrupt outputs are 0, the clock is stopped, and status, mode and mask read 0. The duty compare reads 2^(CNT_W-1) and the period compare reads 2^CNT_W-1, which are 32768 and 65535 at the default width.
- R2: Mode bits [2:0] pick the tick source. Values 0 to 4 give one tick every 2, 8, 32, 128 and 1024 system clocks. Values 5, 6 and 7 count edges of external lines 0, 1 and 2.
- R3: While running, each tick increments the counter. After the counter has taken the period-compare value, the next tick loads zero. Taking the period value sets status bit 0.
- R4: The waveform output goes high when the counter takes the duty-compare value. It goes low when the counter takes the period-compare value, and the low action wins if both happen at once.
- R5: With mode bit 9 set, a period match stops the counter clock, so further ticks have no effect until the channel is started again. With the bit clear, counting continues.
- R6: Control word (address 0) bit 0 enables the clock and bit 1 disables it, with disable winning. Bit 2 is a software trigger that zeroes the counter and drives the waveform low. Writing 5 starts the channel from zero.
- R7: If the counter wraps from its all-ones value to zero without a period match, status bit 1 (overflow) sets.
- R8: Reading the status word (address 4) returns the flags and clears them. An event in the same cycle as the read leaves its flag set.
- R9: The interrupt output is high while any status flag is set whose mask bit is set. Address 5 sets mask bits for ones written, address 6 clears mask bits for ones written, and address 7 reads the mask.
- R10: Mode bit 3 makes an external tick source count falling edges instead of rising edges.
- R11: Mode bits [5:4] select tick gating. With value 0 there is no gating. With values 1, 2 or 3, ticks pass only while external line 0, 1 or 2 is high.
- R12: Mode bits [7:6] select the trigger edge: none, rising, falling or both. Mode bit 8 chooses the auxiliary trigger input (0) or external line 0 (1). A qualified edge acts as a software trigger, and other edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr | input | 3 | Word address: 0 control, 1 mode, 2 duty, 3 period, 4 status, 5 mask set, 6 mask clear, 7 mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| xclk_in | input | 3 | External clock/gate lines, asynchronous |
| aux_trig_in | input | 1 | Auxiliary external trigger input, asynchronous |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value does not appear at the ports directly. It shows as a waveform rise or a period flag that comes one or more ticks early or late, so the bench counts external clock pulses one at a time and samples after each. A wrong tick source or gate shows as flags that arrive too soon or never inside a bounded window. A stale run-enable after a single-shot period shows as extra waveform activity on later pulses. External edges reach the counter three clock edges after the pin changes, and the checks wait longer than that before sampling.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_MODE = 3'd1;
   localparam logic [2:0] A_DUTY = 3'd2;
   localparam logic [2:0] A_PER  = 3'd3;
   localparam logic [2:0] A_STAT = 3'd4;
   localparam logic [2:0] A_MSET = 3'd5;
   localparam logic [2:0] A_MCLR = 3'd6;
   localparam logic [2:0] A_MASK = 3'd7;

   localparam int N_TAPS   = 5;
   localparam int N_XLINES = 3;
   localparam int N_FLAGS  = 2;
   localparam int MODE_W   = 10;

   typedef struct packed {
      logic       stop_on_per;
      logic       trig_src;
      logic [1:0] trig_edge;
      logic [1:0] gate_sel;
      logic       xclk_inv;
      logic [2:0] tick_sel;
   } mode_t;

   function automatic int tap_shift(input int idx);
      case (idx)
         0:       return 1;
         1:       return 3;
         2:       return 5;
         3:       return 7;
         default: return 10;
      endcase
   endfunction
endpackage

// File: rtl/wtc_sync.sv
module wtc_sync #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] lvl,
   output logic [W-1:0] lvl_d
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic s1_q, s2_q, s3_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_q <= 1'b0;
               s2_q <= 1'b0;
               s3_q <= 1'b0;
            end else begin
               s1_q <= async_in[i];
               s2_q <= s1_q;
               s3_q <= s2_q;
            end
         end
         assign lvl[i]   = s2_q;
         assign lvl_d[i] = s3_q;
      end
   endgenerate
endmodule

// File: rtl/wtc_tick_gen.sv
module wtc_tick_gen
   import wtc_pkg::*;
#(
   parameter int PRESC_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          tick_sel,
   input  logic                xclk_inv,
   input  logic [1:0]          gate_sel,
   input  logic [N_XLINES-1:0] x_lvl,
   input  logic [N_XLINES-1:0] x_lvl_d,
   output logic                tick
);
   if (PRESC_W < tap_shift(N_TAPS - 1)) begin : g_bad_presc
      $error("wtc_tick_gen: PRESC_W too small for the slowest tap");
   end

   logic [PRESC_W-1:0] presc_q;
   logic [N_TAPS-1:0]  tap;
   logic [1:0]         x_idx;
   logic               x_edge, raw_tick, gate_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc_q <= '0;
      else        presc_q <= presc_q + 1'b1;
   end

   generate
      for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
         localparam int SH = tap_shift(i);
         assign tap[i] = &presc_q[SH-1:0];
      end
   endgenerate

   assign x_idx  = tick_sel[1:0] - 2'd1;
   assign x_edge = xclk_inv ? (~x_lvl[x_idx] &  x_lvl_d[x_idx])
                            : ( x_lvl[x_idx] & ~x_lvl_d[x_idx]);

   always_comb begin
      case (tick_sel)
         3'd0:    raw_tick = tap[0];
         3'd1:    raw_tick = tap[1];
         3'd2:    raw_tick = tap[2];
         3'd3:    raw_tick = tap[3];
         3'd4:    raw_tick = tap[4];
         default: raw_tick = x_edge;
      endcase
   end

   assign gate_ok = (gate_sel == 2'd0) ? 1'b1 : x_lvl[gate_sel - 2'd1];
   assign tick    = raw_tick & gate_ok;

   AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_sel != 2'd0 && !x_lvl[gate_sel - 2'd1]) |-> !tick); // R11
endmodule

// File: rtl/wtc_trig_det.sv
module wtc_trig_det (
   input  logic       aux_lvl,
   input  logic       aux_lvl_d,
   input  logic       x0_lvl,
   input  logic       x0_lvl_d,
   input  logic       trig_src,
   input  logic [1:0] trig_edge,
   output logic       ext_trig
);
   logic cur, prev, rise, fall;

   assign cur  = trig_src ? x0_lvl   : aux_lvl;
   assign prev = trig_src ? x0_lvl_d : aux_lvl_d;
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   always_comb begin
      case (trig_edge)
         2'd1:    ext_trig = rise;
         2'd2:    ext_trig = fall;
         2'd3:    ext_trig = rise | fall;
         default: ext_trig = 1'b0;
      endcase
   end
endmodule

// File: rtl/wtc_core.sv
module wtc_core
   import wtc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic               trig,
   input  logic               stop_on_per,
   input  logic [CNT_W-1:0]   duty,
   input  logic [CNT_W-1:0]   period,
   input  logic               stat_clr,
   output logic [N_FLAGS-1:0] flags,
   output logic               wave
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             run_q, wave_q, per_f_q, ovf_f_q;
   logic             step, per_evt, duty_evt, ovf_evt;

   assign step     = run_q & tick & ~trig;
   assign cnt_nxt  = (cnt_q == period) ? '0 : cnt_q + 1'b1;
   assign per_evt  = step & (cnt_nxt == period);
   assign duty_evt = step & (cnt_nxt == duty);
   assign ovf_evt  = step & (cnt_q == CNT_MAX) & (cnt_q != period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         wave_q  <= 1'b0;
         per_f_q <= 1'b0;
         ovf_f_q <= 1'b0;
      end else begin
         if (dis_req)                            run_q <= 1'b0;
         else if (en_req)                        run_q <= 1'b1;
         else if (per_evt && stop_on_per)        run_q <= 1'b0;

         if (trig)      cnt_q <= '0;
         else if (step) cnt_q <= cnt_nxt;

         if (trig || per_evt) wave_q <= 1'b0;
         else if (duty_evt)   wave_q <= 1'b1;

         per_f_q <= per_evt | (per_f_q & ~stat_clr);
         ovf_f_q <= ovf_evt | (ovf_f_q & ~stat_clr);
      end
   end

   assign flags = {ovf_f_q, per_f_q};
   assign wave  = wave_q;

   AST_WAVE_LOW_AFTER_PER: assert property (@(posedge clk) disable iff (!rst_n)
      per_evt |=> !wave_q); // R4
   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (per_evt && stop_on_per && !en_req) |=> !run_q); // R5
   AST_TRIG_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (cnt_q == '0 && !wave_q)); // R6
   AST_STOPPED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !en_req) |=> !run_q); // R6
   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_f_q); // R7
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (per_evt && stat_clr) |=> per_f_q); // R8
endmodule

// File: rtl/wtc_channel.sv
module wtc_channel
   import wtc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PRESC_W = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [2:0]  xclk_in,
   input  logic        aux_trig_in,
   output logic        wave_out,
   output logic        irq
);
   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
      $error("wtc_channel: CNT_W must lie in 4..32");
   end

   localparam logic [CNT_W-1:0] DUTY_RST = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] PER_RST  = '1;

   mode_t              mode_q;
   logic [CNT_W-1:0]   duty_q, per_q;
   logic [N_FLAGS-1:0] mask_q, flags;
   logic               wr_ctrl, en_req, dis_req, sw_trig, ext_trig, tick, stat_clr;
   logic [N_XLINES:0]  s_lvl, s_lvl_d;
   logic               unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
   assign en_req   = wr_ctrl && reg_wdata[0];
   assign dis_req  = wr_ctrl && reg_wdata[1];
   assign sw_trig  = wr_ctrl && reg_wdata[2];
   assign stat_clr = reg_rd && reg_addr == A_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         duty_q <= DUTY_RST;
         per_q  <= PER_RST;
         mask_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_MODE: mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
            A_DUTY: duty_q <= reg_wdata[CNT_W-1:0];
            A_PER:  per_q  <= reg_wdata[CNT_W-1:0];
            A_MSET: mask_q <= mask_q | reg_wdata[N_FLAGS-1:0];
            A_MCLR: mask_q <= mask_q & ~reg_wdata[N_FLAGS-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_MODE: reg_rdata[MODE_W-1:0]  = mode_q;
         A_DUTY: reg_rdata[CNT_W-1:0]   = duty_q;
         A_PER:  reg_rdata[CNT_W-1:0]   = per_q;
         A_STAT: reg_rdata[N_FLAGS-1:0] = flags;
         A_MASK: reg_rdata[N_FLAGS-1:0] = mask_q;
         default: ;
      endcase
   end

   wtc_sync #(.W(N_XLINES + 1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in({aux_trig_in, xclk_in}),
      .lvl(s_lvl), .lvl_d(s_lvl_d));

   wtc_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_sel(mode_q.tick_sel),
      .xclk_inv(mode_q.xclk_inv), .gate_sel(mode_q.gate_sel),
      .x_lvl(s_lvl[N_XLINES-1:0]), .x_lvl_d(s_lvl_d[N_XLINES-1:0]), .tick(tick));

   wtc_trig_det u_trig (
      .aux_lvl(s_lvl[N_XLINES]), .aux_lvl_d(s_lvl_d[N_XLINES]),
      .x0_lvl(s_lvl[0]), .x0_lvl_d(s_lvl_d[0]),
      .trig_src(mode_q.trig_src), .trig_edge(mode_q.trig_edge), .ext_trig(ext_trig));

   wtc_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en_req(en_req), .dis_req(dis_req),
      .trig(sw_trig | ext_trig), .stop_on_per(mode_q.stop_on_per),
      .duty(duty_q), .period(per_q), .stat_clr(stat_clr), .flags(flags), .wave(wave_out));

   assign irq = |(flags & mask_q);

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R9
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !tick) |=> (flags == '0)); // R8
endmodule

// File: tb/sim_wtc_channel.sv
module sim_wtc_channel;
   localparam int CW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  xclk_in = '0;
   logic        aux_trig_in = 1'b0;
   logic        wave_out, irq;
   int          n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   wtc_channel #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xclk_in(xclk_in),
      .aux_trig_in(aux_trig_in), .wave_out(wave_out), .irq(irq));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xpulse(input int line);
      xclk_in[line] = 1'b1; idle(4);
      xclk_in[line] = 1'b0; idle(4);
   endtask

   task automatic setup(input logic [31:0] mode, input logic [31:0] duty, input logic [31:0] per);
      logic [31:0] d;
      wr(3'd0, 32'h2);
      wr(3'd1, mode); wr(3'd2, duty); wr(3'd3, per);
      rd(3'd4, d);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 wave", {31'b0, wave_out}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd(3'd2, d); chk("R1 duty", d, 32'h80);
      rd(3'd3, d); chk("R1 period", d, 32'hFF);
      rd(3'd1, d); chk("R1 mode", d, 32'h0);
      rd(3'd7, d); chk("R1 mask", d, 32'h0);
      rd(3'd4, d); chk("R1 status", d, 32'h0);
   endtask

   task automatic t_continuous;
      logic [31:0] d;
      setup(32'h5, 2, 4);
      wr(3'd0, 32'h5);
      xpulse(0); chk("R3 cnt1 wave", {31'b0, wave_out}, 0);
      xpulse(0); chk("R4 duty sets wave", {31'b0, wave_out}, 1);
      xpulse(0);
      rd(3'd4, d); chk("R3 no period yet", d, 0);
      xpulse(0); chk("R4 period clears wave", {31'b0, wave_out}, 0);
      rd(3'd4, d); chk("R3 period flag", d, 1);
      rd(3'd4, d); chk("R8 read cleared", d, 0);
      xpulse(0); xpulse(0);
      chk("R3 wrap to zero", {31'b0, wave_out}, 0);
      xpulse(0); chk("R3 second period duty", {31'b0, wave_out}, 1);
   endtask

   task automatic t_equal_compares;
      setup(32'h5, 3, 3);
      wr(3'd0, 32'h5);
      xpulse(0); xpulse(0); xpulse(0);
      chk("R4 clear wins on equal", {31'b0, wave_out}, 0);
   endtask

   task automatic t_oneshot;
      logic [31:0] d;
      setup(32'h205, 2, 4);
      wr(3'd0, 32'h5);
      for (int i = 0; i < 4; i++) xpulse(0);
      rd(3'd4, d); chk("R5 single period flag", d, 1);
      for (int i = 0; i < 6; i++) xpulse(0);
      chk("R5 halted wave", {31'b0, wave_out}, 0);
      rd(3'd4, d); chk("R5 halted status", d, 0);
      wr(3'd0, 32'h5);
      xpulse(0); xpulse(0);
      chk("R5 restart counts", {31'b0, wave_out}, 1);
   endtask

   task automatic t_prescale;
      logic [31:0] d;
      setup(32'h0, 100, 3);
      wr(3'd0, 32'h5); idle(20);
      rd(3'd4, d); chk("R2 div2 period", d, 1);
      setup(32'h1, 100, 3);
      wr(3'd0, 32'h5); idle(12);
      rd(3'd4, d); chk("R2 div8 early", d, 0);
      idle(30);
      rd(3'd4, d); chk("R2 div8 late", d, 1);
      setup(32'h4, 100, 3);
      wr(3'd0, 32'h5); idle(100);
      rd(3'd4, d); chk("R2 div1024 early", d, 0);
      idle(4200);
      rd(3'd4, d); chk("R2 div1024 late", d, 1);
   endtask

   task automatic t_overflow;
      logic [31:0] d;
      setup(32'h0, 200, 255);
      wr(3'd0, 32'h5); idle(20);
      wr(3'd3, 3); idle(700);
      rd(3'd4, d); chk("R7 overflow plus period", d, 3);
   endtask

   task automatic t_invert;
      setup(32'hE, 1, 10);
      wr(3'd0, 32'h5);
      xclk_in[1] = 1'b1; idle(4);
      chk("R10 rising ignored", {31'b0, wave_out}, 0);
      xclk_in[1] = 1'b0; idle(4);
      chk("R10 falling counts", {31'b0, wave_out}, 1);
   endtask

   task automatic t_burst;
      setup(32'h25, 1, 10);
      wr(3'd0, 32'h5);
      xpulse(0); xpulse(0);
      chk("R11 gated off", {31'b0, wave_out}, 0);
      xclk_in[1] = 1'b1; idle(4);
      xpulse(0);
      chk("R11 gate open", {31'b0, wave_out}, 1);
      xclk_in[1] = 1'b0; idle(4);
   endtask

   task automatic t_swtrig_disable;
      setup(32'h5, 1, 10);
      wr(3'd0, 32'h5); xpulse(0);
      chk("R6 running", {31'b0, wave_out}, 1);
      wr(3'd0, 32'h4);
      chk("R6 sw trigger clears", {31'b0, wave_out}, 0);
      wr(3'd0, 32'h2); xpulse(0);
      chk("R6 disabled no count", {31'b0, wave_out}, 0);
      wr(3'd0, 32'h3); xpulse(0);
      chk("R6 disable wins", {31'b0, wave_out}, 0);
   endtask

   task automatic t_exttrig;
      setup(32'h46, 1, 10);
      wr(3'd0, 32'h5); xpulse(1);
      chk("R12 pre", {31'b0, wave_out}, 1);
      aux_trig_in = 1'b1; idle(4);
      chk("R12 rising aux trigger", {31'b0, wave_out}, 0);
      aux_trig_in = 1'b0; idle(4);
      xpulse(1);
      wr(3'd1, 32'h86);
      aux_trig_in = 1'b1; idle(4);
      chk("R12 rising ignored when falling", {31'b0, wave_out}, 1);
      aux_trig_in = 1'b0; idle(4);
      chk("R12 falling trigger", {31'b0, wave_out}, 0);
      wr(3'd1, 32'h1C6); xpulse(1);
      aux_trig_in = 1'b1; idle(4); aux_trig_in = 1'b0; idle(4);
      chk("R12 aux ignored with line src", {31'b0, wave_out}, 1);
      xclk_in[0] = 1'b1; idle(4);
      chk("R12 line0 trigger", {31'b0, wave_out}, 0);
      xclk_in[0] = 1'b0; idle(4);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      setup(32'h5, 5, 2);
      wr(3'd5, 32'h1);
      rd(3'd7, d); chk("R9 mask set", d, 1);
      wr(3'd0, 32'h5); xpulse(0);
      chk("R9 no irq yet", {31'b0, irq}, 0);
      xpulse(0);
      chk("R9 irq on period", {31'b0, irq}, 1);
      rd(3'd4, d);
      chk("R9 irq drops after read", {31'b0, irq}, 0);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd7, d); chk("R9 mask cleared", d, 0);
      xpulse(0); xpulse(0); xpulse(0);
      chk("R9 masked no irq", {31'b0, irq}, 0);
      rd(3'd4, d); chk("R9 flag still latched", d, 1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_continuous();
      t_equal_compares();
      t_oneshot();
      t_prescale();
      t_overflow();
      t_invert();
      t_burst();
      t_swtrig_disable();
      t_exttrig();
      t_irq();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule